// File: doc/BRIEF.md
# USB Slave-FIFO Byte Bridge

This block connects two internal 32-bit word streams to a USB peripheral controller that offers an 8-bit synchronous slave-FIFO port. Everything runs on the 48 MHz interface clock that the controller supplies.

On the transmit path, words arriving on a valid/ready stream are split into bytes. The bytes are written with a write strobe to the IN endpoint the user has selected. On the receive path, bytes are read from the fixed receive endpoint and packed back into words. The packed words leave on a second valid/ready stream.

A small arbiter owns the shared data bus. It normally sits on the selected transmit endpoint. When the controller's receive-empty flag shows that data has arrived, it moves to the receive endpoint and releases the bus. It raises the output enable one cycle later, reads until the flag shows empty again, and then returns to transmitting.

The bus is modelled as three pins: input data, output data and a drive enable. The pad-level tristate buffer sits outside the block.

Top module: `usb_sfifo_bridge`

## Requirements
- R1: While reset is held, wr_stb, rd_stb and oe are 0, fd_drive is 1, fd_out is 0 and rx_valid is 0.
- R2: ep_addr carries ep_sel in every cycle in which wr_stb is 1, and 2'b11 (the receive endpoint) in every cycle in which oe or rd_stb is 1. The endpoint codes are 00, 01, 10 and 11 for the four endpoints.
- R3: Each accepted transmit word leaves on fd_out as four byte writes, bits 7:0 first and bits 31:24 last, with words in acceptance order.
- R4: wr_stb is never 1 while ext_txfull_n is 0 (low means the external endpoint is full). Writing resumes once the flag goes high.
- R5: When ext_rxempty_n goes high while the bridge is idle on transmit and can take a byte, ep_addr is 2'b11 in the next cycle with oe 0. In the cycle after that, oe and rd_stb are 1.
- R6: fd_drive is 0 in every cycle in which oe is 1, and also in the cycle just before oe rises.
- R7: rd_stb is never 1 while ext_rxempty_n is 0 (low means the receive endpoint is empty). Bytes waiting behind a low flag are not taken.
- R8: Received bytes are packed with the first byte in bits 7:0. rx_valid rises only once four bytes have been collected.
- R9: After the receive flag drops, the bridge returns to ep_sel and continues the interrupted transmit word with no byte lost or repeated.
- R10: While rx_valid is 1 and rx_ready is 0, rx_data is stable and no further byte is read once the next word would need the output register.
- R11: tx_ready is 0 while a word is still being unpacked, unless its last byte is being written in that cycle. No write occurs without a held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock from the USB controller |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 32 | Transmit stream word |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Bridge can accept a transmit word |
| rx_data | output | 32 | Packed receive word |
| rx_valid | output | 1 | Receive word valid |
| rx_ready | input | 1 | Consumer accepts receive word |
| ep_sel | input | 2 | User-selected transmit endpoint code |
| ext_txfull_n | input | 1 | External TX endpoint full flag, low = full |
| ext_rxempty_n | input | 1 | External RX endpoint empty flag, low = empty |
| wr_stb | output | 1 | Byte write strobe to the controller |
| rd_stb | output | 1 | Byte read strobe to the controller |
| oe | output | 1 | Controller output enable (controller drives bus) |
| ep_addr | output | 2 | Endpoint address to the controller |
| fd_in | input | 8 | Data bus as seen at the pad |
| fd_out | output | 8 | Data the bridge places on the bus |
| fd_drive | output | 1 | Bridge drives the bus when 1 |

## Verification
A corrupted byte index in the unpacker shows at once as a swapped or repeated byte on fd_out, on the next write strobe. A lost arbiter state shows within one cycle as either oe and fd_drive high together, or oe rising straight out of a cycle where the bridge still drove the bus. A miscounted packer lane shows as a shifted word, or as rx_valid rising after three or five reads rather than four. The scoreboard detects this at the first handshake that follows.

// File: rtl/usb_sfifo_pkg.sv
`timescale 1ns/1ps
package usb_sfifo_pkg;
   localparam int EP_W = 2;
   localparam logic [EP_W-1:0] EP_RX_CODE = 2'b11;

   typedef enum logic [1:0] {
      ARB_TX   = 2'd0,
      ARB_TURN = 2'd1,
      ARB_RD   = 2'd2,
      ARB_BACK = 2'd3
   } arb_state_t;
endpackage

// File: rtl/usb_tx_unpack.sv
`timescale 1ns/1ps
module usb_tx_unpack #(
   parameter int WORD_W    = 32,
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] s_data,
   input  logic              s_valid,
   output logic              s_ready,
   output logic [BYTE_W-1:0] byte_out,
   output logic              byte_vld,
   input  logic              byte_take
);
   localparam int LANES = WORD_W / BYTE_W;
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

   if (WORD_W % BYTE_W != 0 || LANES < 2) begin : g_bad_width
      $error("usb_tx_unpack: WORD_W must be a multiple (>=2) of BYTE_W");
   end

   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;
   logic              hold_q;
   logic [IDX_W-1:0]  lane;
   logic              last;

   if (LSB_FIRST) begin : g_lsb
      assign lane = idx_q;
   end else begin : g_msb
      assign lane = LAST_IDX - idx_q;
   end

   assign last     = (idx_q == LAST_IDX);
   assign s_ready  = !hold_q || (byte_take && last);
   assign byte_vld = hold_q;
   assign byte_out = hold_q ? word_q[lane*BYTE_W +: BYTE_W] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         idx_q  <= '0;
         hold_q <= 1'b0;
      end else if (s_valid && s_ready) begin
         word_q <= s_data;
         idx_q  <= '0;
         hold_q <= 1'b1;
      end else if (byte_take) begin
         idx_q <= idx_q + 1'b1;
         if (last) hold_q <= 1'b0;
      end
   end

   // R11
   take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_take |-> hold_q);

   // R11
   ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !byte_take) |-> !s_ready);
endmodule

// File: rtl/usb_rx_pack.sv
`timescale 1ns/1ps
module usb_rx_pack #(
   parameter int WORD_W    = 32,
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              byte_stb,
   output logic [WORD_W-1:0] m_data,
   output logic              m_valid,
   input  logic              m_ready,
   output logic              space
);
   localparam int LANES = WORD_W / BYTE_W;
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

   if (WORD_W % BYTE_W != 0 || LANES < 2) begin : g_bad_width
      $error("usb_rx_pack: WORD_W must be a multiple (>=2) of BYTE_W");
   end

   logic [WORD_W-1:0] acc_q, acc_nx, out_q;
   logic [IDX_W-1:0]  cnt_q;
   logic              vld_q;
   logic [IDX_W-1:0]  lane;

   if (LSB_FIRST) begin : g_lsb
      assign lane = cnt_q;
   end else begin : g_msb
      assign lane = LAST_IDX - cnt_q;
   end

   always_comb begin
      acc_nx = acc_q;
      acc_nx[lane*BYTE_W +: BYTE_W] = byte_in;
   end

   assign space   = !vld_q || m_ready;
   assign m_valid = vld_q;
   assign m_data  = out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         out_q <= '0;
         cnt_q <= '0;
         vld_q <= 1'b0;
      end else begin
         if (vld_q && m_ready) vld_q <= 1'b0;
         if (byte_stb) begin
            acc_q <= acc_nx;
            if (cnt_q == LAST_IDX) begin
               cnt_q <= '0;
               out_q <= acc_nx;
               vld_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R10
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

   // R10
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb |-> space);
endmodule

// File: rtl/usb_bus_arbiter.sv
`timescale 1ns/1ps
module usb_bus_arbiter
   import usb_sfifo_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EP_W-1:0] ep_sel,
   input  logic            rx_avail,
   input  logic            tx_room,
   input  logic            tx_have,
   input  logic            rx_space,
   output logic            wr_stb,
   output logic            rd_stb,
   output logic            oe,
   output logic            fd_drive,
   output logic [EP_W-1:0] ep_addr
);
   arb_state_t st_q, st_nx;
   logic go_rx;

   assign go_rx = rx_avail && rx_space;

   always_comb begin
      st_nx    = st_q;
      wr_stb   = 1'b0;
      rd_stb   = 1'b0;
      oe       = 1'b0;
      fd_drive = 1'b0;
      ep_addr  = ep_sel;
      unique case (st_q)
         ARB_TX: begin
            fd_drive = 1'b1;
            wr_stb   = tx_have && tx_room && !go_rx;
            if (go_rx) st_nx = ARB_TURN;
         end
         ARB_TURN: begin
            ep_addr = EP_RX_CODE;
            st_nx   = ARB_RD;
         end
         ARB_RD: begin
            ep_addr = EP_RX_CODE;
            oe      = 1'b1;
            rd_stb  = go_rx;
            if (!go_rx) st_nx = ARB_BACK;
         end
         ARB_BACK: begin
            st_nx = ARB_TX;
         end
         default: st_nx = ARB_TX;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ARB_TX;
      else        st_q <= st_nx;
   end

   // R6
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> !fd_drive);

   // R6
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(!fd_drive));

   // R4
   no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> tx_room);

   // R7
   no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> (rx_avail && oe));

   // R2
   rx_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> (ep_addr == EP_RX_CODE));

   // R2
   tx_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (ep_addr == ep_sel && !rd_stb));
endmodule

// File: rtl/usb_sfifo_bridge.sv
`timescale 1ns/1ps
module usb_sfifo_bridge
   import usb_sfifo_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   input  logic [EP_W-1:0]   ep_sel,
   input  logic              ext_txfull_n,
   input  logic              ext_rxempty_n,
   output logic              wr_stb,
   output logic              rd_stb,
   output logic              oe,
   output logic [EP_W-1:0]   ep_addr,
   input  logic [BYTE_W-1:0] fd_in,
   output logic [BYTE_W-1:0] fd_out,
   output logic              fd_drive
);
   logic tx_have, rx_space;

   usb_tx_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_data   (tx_data),
      .s_valid  (tx_valid),
      .s_ready  (tx_ready),
      .byte_out (fd_out),
      .byte_vld (tx_have),
      .byte_take(wr_stb)
   );

   usb_rx_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_in (fd_in),
      .byte_stb(rd_stb),
      .m_data  (rx_data),
      .m_valid (rx_valid),
      .m_ready (rx_ready),
      .space   (rx_space)
   );

   usb_bus_arbiter u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .ep_sel  (ep_sel),
      .rx_avail(ext_rxempty_n),
      .tx_room (ext_txfull_n),
      .tx_have (tx_have),
      .rx_space(rx_space),
      .wr_stb  (wr_stb),
      .rd_stb  (rd_stb),
      .oe      (oe),
      .fd_drive(fd_drive),
      .ep_addr (ep_addr)
   );
endmodule

// File: tb/usb_sfifo_bridge_bench.sv
`timescale 1ns/1ps
module usb_sfifo_bridge_bench;
   localparam int CAP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [31:0] rx_data;
   logic        rx_valid;
   logic        rx_ready = 1'b1;
   logic [1:0]  ep_sel = 2'b00;
   logic        ext_txfull_n = 1'b1;
   logic        ext_rxempty_n = 1'b0;
   logic        wr_stb, rd_stb, oe, fd_drive;
   logic [1:0]  ep_addr;
   logic [7:0]  fd_in = '0;
   logic [7:0]  fd_out;

   usb_sfifo_bridge u_usb_sfifo_bridge (.*);

   always #5 clk = ~clk;

   int checks = 0, fails = 0;
   logic [7:0]  tx_exp[$];
   logic [7:0]  rx_src[$];
   logic [31:0] rx_exp[$];
   int  ep_cnt = 0;
   bit  drain_en = 1'b1, rx_gate = 1'b1, sent_done = 1'b0;

   // values latched just before each rising edge
   logic l_wr = 0, l_rd = 0, l_oe = 0, l_drive = 1, l_full_n = 1, l_rxe_n = 0;
   logic l_hs = 0, p_oe = 0, p_drive = 1;
   logic [7:0]  l_fd = 0;
   logic [1:0]  l_ep = 0, l_epsel = 0;
   logic [31:0] l_rxd = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // external controller model and scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (l_wr) begin
               check(l_full_n, "R4 write while full", {31'd0, l_full_n}, 32'd1);
               check(l_ep == l_epsel, "R2 write endpoint", {30'd0, l_ep}, {30'd0, l_epsel});
               if (tx_exp.size() == 0) check(1'b0, "R11 write without word", {24'd0, l_fd}, 32'd0);
               else begin
                  logic [7:0] e;
                  e = tx_exp.pop_front();
                  check(l_fd == e, "R3 tx byte", {24'd0, l_fd}, {24'd0, e});
               end
               ep_cnt++;
            end
            if (l_rd) begin
               check(l_rxe_n, "R7 read while empty", {31'd0, l_rxe_n}, 32'd1);
               check(l_ep == 2'b11, "R2 read endpoint", {30'd0, l_ep}, 32'd3);
               if (rx_src.size() > 0) void'(rx_src.pop_front());
            end
            if (l_oe) check(!l_drive, "R6 bus contention", {31'd0, l_drive}, 32'd0);
            if (l_oe && !p_oe) check(!p_drive, "R6 turnaround", {31'd0, p_drive}, 32'd0);
            if (l_hs) begin
               if (rx_exp.size() == 0) check(1'b0, "R8 unexpected rx word", l_rxd, 32'd0);
               else begin
                  logic [31:0] w;
                  w = rx_exp.pop_front();
                  check(l_rxd == w, "R8 rx word", l_rxd, w);
               end
            end
            if (drain_en && ep_cnt > 0) ep_cnt--;
         end
         ext_txfull_n  = (ep_cnt < CAP);
         ext_rxempty_n = rx_gate && (rx_src.size() > 0);
         fd_in         = (rx_src.size() > 0) ? rx_src[0] : 8'h00;
         #4;
         p_oe = l_oe; p_drive = l_drive;
         l_wr = wr_stb; l_rd = rd_stb; l_oe = oe; l_drive = fd_drive;
         l_full_n = ext_txfull_n; l_rxe_n = ext_rxempty_n;
         l_fd = fd_out; l_ep = ep_addr; l_epsel = ep_sel;
         l_hs = rx_valid && rx_ready; l_rxd = rx_data;
      end
   end

   task automatic send_word(input logic [31:0] w);
      @(negedge clk); #2;
      tx_data = w; tx_valid = 1'b1;
      for (int i = 0; i < 4; i++) tx_exp.push_back(w[i*8 +: 8]);
      #1;
      while (!tx_ready) begin @(negedge clk); #3; end
      @(posedge clk); #1;
      tx_valid = 1'b0;
   endtask

   task automatic feed_rx(input logic [31:0] w);
      @(negedge clk); #2;
      for (int i = 0; i < 4; i++) rx_src.push_back(w[i*8 +: 8]);
      rx_exp.push_back(w);
   endtask

   task automatic wait_idle();
      while (tx_exp.size() > 0 || rx_exp.size() > 0 || rx_src.size() > 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      summary();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      #4;
      check(!wr_stb && !rd_stb && !oe, "R1 strobes in reset", {29'd0, wr_stb, rd_stb, oe}, 32'd0);
      check(fd_drive && fd_out == 8'h00, "R1 bus drives zero", {23'd0, fd_drive, fd_out}, 32'h100);
      check(!rx_valid, "R1 rx_valid", {31'd0, rx_valid}, 32'd0);
      @(negedge clk); #2; rst_n = 1'b1;

      // R3 and R2: byte order on a chosen endpoint
      ep_sel = 2'b01;
      send_word(32'h44332211);
      send_word(32'h88776655);
      send_word(32'hDDCCBBAA);
      wait_idle();

      // R4 and R11: stall on a full endpoint
      drain_en = 1'b0;
      sent_done = 1'b0;
      fork
         begin
            send_word(32'h03020100);
            send_word(32'h07060504);
            send_word(32'h0B0A0908);
            sent_done = 1'b1;
         end
      join_none
      repeat (40) @(negedge clk);
      #4;
      check(ep_cnt == CAP, "R4 endpoint filled to capacity", ep_cnt, CAP);
      check(!wr_stb && !tx_ready, "R11 stalled with word held", {30'd0, wr_stb, tx_ready}, 32'd0);
      drain_en = 1'b1;
      wait (sent_done);
      wait_idle();

      // R5 and R6: switch to the receive endpoint
      feed_rx(32'hA1B2C3D4);
      @(negedge clk); @(negedge clk); #4;
      check(ep_addr == 2'b11 && !oe && !fd_drive, "R5 turn cycle", {27'd0, ep_addr, oe, fd_drive, 1'b0}, 32'h18);
      @(negedge clk); #4;
      check(oe && rd_stb, "R5 read begins", {30'd0, oe, rd_stb}, 32'd3);
      feed_rx(32'h5E6F7081);
      wait_idle();
      check(ep_addr == 2'b01 && fd_drive, "R9 back on tx endpoint", {29'd0, ep_addr, fd_drive}, 32'd3);

      // R9: receive interrupts a transmit stream
      ep_sel = 2'b10;
      sent_done = 1'b0;
      fork
         begin
            for (int k = 0; k < 6; k++) send_word(32'h10203040 + k * 32'h01010101);
            sent_done = 1'b1;
         end
      join_none
      repeat (5) @(negedge clk);
      feed_rx(32'hCAFE0123);
      feed_rx(32'h4567BEEF);
      wait (sent_done);
      wait_idle();
      #4;
      check(ep_addr == 2'b10, "R9 endpoint restored", {30'd0, ep_addr}, 32'd2);

      // R10: back-pressure on the receive stream
      @(negedge clk); #2; rx_ready = 1'b0;
      feed_rx(32'h11112222);
      feed_rx(32'h33334444);
      feed_rx(32'h55556666);
      repeat (30) @(negedge clk);
      #4;
      check(rx_valid && rx_data == 32'h11112222, "R10 word held", rx_data, 32'h11112222);
      check(rx_src.size() == 8, "R10 reads paused", rx_src.size(), 32'd8);
      @(negedge clk); #2; rx_ready = 1'b1;
      wait_idle();

      // R7 and R8: bytes behind a low empty flag are left alone
      @(negedge clk); #2; rx_gate = 1'b0;
      feed_rx(32'hF00DF00D);
      repeat (10) @(negedge clk);
      #4;
      check(rx_src.size() == 4 && !rx_valid, "R7 no read while empty", rx_src.size(), 32'd4);
      check(!oe && fd_drive, "R7 stays on transmit", {30'd0, oe, fd_drive}, 32'd1);
      @(negedge clk); #2; rx_gate = 1'b1;
      wait_idle();

      check(tx_exp.size() == 0 && rx_exp.size() == 0, "R8 scoreboard drained",
            tx_exp.size() + rx_exp.size(), 32'd0);
      summary();
   end
endmodule